// File: doc/BRIEF.md
# Handshake Command and Digit Sender

This block sits on the host side of a serial-entry arithmetic coprocessor. It feeds that coprocessor one 6-bit word at a time: a BCD digit or an instruction, whose low four bits carry the digit or the low instruction bits. Words arrive from an upstream valid/ready interface. Each accepted word is held on a registered output bus. A hold line tells the coprocessor whether a word is waiting. The coprocessor raises its ready line when it can take input, and it waits for as long as hold is high. Once hold is low, it lowers ready and samples the bus. It may sample the bus several times, so the word stays latched until the next transfer.

After a reset, the block drives a reset output to the coprocessor for a programmable number of clock cycles. It then keeps hold low while the coprocessor emits its start-up ready pulses, and it discards exactly two of them. Only after that does it offer upstream a slot for the first word. The ready input and the error flag come from another clock domain, so both pass through two-flop synchronizers. The error flag is passed on to the host unchanged apart from that delay.

Top module: `cop_word_sender`

## Requirements
- R1: While `rst` is high, the outputs take these values after the next clock edge: `cop_reset`=1, `cop_hold`=0, `in_ready`=0, `cop_word`=0 and `err_out`=0.
- R2: After `rst` is released, `cop_reset` stays high for exactly RESET_CYCLES clock cycles (default 8, never below 8), then falls.
- R3: From reset until the second start-up high pulse on `cop_rdy` has ended, `cop_hold` and `in_ready` stay low. `in_ready` rises on the third clock edge after the second pulse's falling level is applied.
- R4: When no word is latched and waiting, `cop_hold` is high, so the coprocessor keeps waiting with `cop_rdy` high, however long upstream stays idle.
- R5: From the edge that accepts a word until the coprocessor's falling `cop_rdy` has been seen through the synchronizer, `cop_hold` is low.
- R6: Every accepted 6-bit word reaches `cop_word` unchanged, in acceptance order. All 64 codes are valid.
- R7: `cop_word` changes only on an accepting edge (`in_valid` and `in_ready` both high). It holds its value through any number of coprocessor samples.
- R8: After word n≥1 of a session has been accepted, the next word is accepted only after `cop_rdy` has fallen for word n and then risen again. `in_ready` is low on the cycle after any acceptance.
- R9: `err_out` reproduces `cop_err` two clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream word valid |
| in_word | input | WORD_W | Upstream word (digit or instruction) |
| in_ready | output | 1 | Block can accept a word this cycle |
| cop_rdy | input | 1 | Coprocessor ready line (asynchronous) |
| cop_err | input | 1 | Coprocessor error flag (asynchronous) |
| cop_word | output | WORD_W | Latched word presented to the coprocessor |
| cop_hold | output | 1 | High: coprocessor must wait |
| cop_reset | output | 1 | Reset pulse to the coprocessor |
| err_out | output | 1 | Synchronized error flag |

## Verification
Every reaction to `cop_rdy` is three edges late: two synchronizer stages, plus the edge register that turns the level into a rise or fall event. The bench therefore samples `in_ready` at the second and third falling clock edges after the second start-up pulse drops. It samples `cop_hold` one falling edge after it lowers ready, while that change cannot yet have arrived. `cop_reset` is counted from the releasing falling edge. `err_out` is checked one edge after a change of `cop_err`, when it must still be old, and again after two edges, when it must be new. Checks on word order, word stability and hold-while-idle tolerate the synchronizer delay: they sample only inside windows that the handshake itself keeps open.

// File: rtl/cws_pkg.sv
package cws_pkg;

    localparam int WORD_W_DEF   = 6;
    localparam int SYNC_STAGES  = 2;

    // Events derived from the synchronized ready line.
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } rdy_ev_t;

    // Start-up sequencer phases.
    typedef enum logic [1:0] {
        PH_RESET = 2'd0,
        PH_SKIP  = 2'd1,
        PH_RUN   = 2'd2
    } start_ph_e;

    // Word link states.
    typedef enum logic [1:0] {
        LK_EMPTY = 2'd0,
        LK_OFFER = 2'd1,
        LK_TAKEN = 2'd2
    } link_st_e;

    function automatic logic hold_for(input link_st_e st, input logic run);
        return run && (st != LK_OFFER);
    endfunction

endpackage

// File: rtl/cws_sync.sv
module cws_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cws_edge.sv
module cws_edge
    import cws_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    lvl,
    output rdy_ev_t ev
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    always_comb begin
        ev.level = lvl;
        ev.rise  = lvl & ~prev;
        ev.fall  = ~lvl & prev;
    end
endmodule

// File: rtl/cws_startup.sv
module cws_startup
    import cws_pkg::*;
#(
    parameter int RESET_CYCLES   = 8,
    parameter int STARTUP_PULSES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  rdy_ev_t ev,
    output logic    cop_reset,
    output logic    run
);
    localparam int CW = $clog2(RESET_CYCLES + 1);
    localparam int PW = $clog2(STARTUP_PULSES + 1);
    localparam logic [CW-1:0] C_LAST = CW'(RESET_CYCLES - 1);
    localparam logic [PW-1:0] P_LAST = PW'(STARTUP_PULSES - 1);

    start_ph_e     ph;
    logic [CW-1:0] cyc;
    logic [PW-1:0] pulses;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_RESET;
            cyc    <= '0;
            pulses <= '0;
        end else begin
            unique case (ph)
                PH_RESET: begin
                    if (cyc == C_LAST) ph  <= PH_SKIP;
                    else               cyc <= cyc + 1'b1;
                end
                PH_SKIP: begin
                    if (ev.fall) begin
                        if (pulses == P_LAST) ph <= PH_RUN;
                        else                  pulses <= pulses + 1'b1;
                    end
                end
                default: ph <= PH_RUN;
            endcase
        end
    end

    assign cop_reset = (ph == PH_RESET);
    assign run       = (ph == PH_RUN);
endmodule

// File: rtl/cws_link.sv
module cws_link
    import cws_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  rdy_ev_t           ev,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic [WORD_W-1:0] cop_word,
    output logic              cop_hold
);
    link_st_e st;
    logic     take;

    assign in_ready = run && (st == LK_EMPTY);
    assign take     = in_ready && in_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= LK_EMPTY;
            cop_word <= '0;
        end else begin
            if (take) cop_word <= in_word;
            unique case (st)
                LK_EMPTY: if (take)    st <= LK_OFFER;
                LK_OFFER: if (ev.fall) st <= LK_TAKEN;
                LK_TAKEN: if (ev.rise) st <= LK_EMPTY;
                default:               st <= LK_EMPTY;
            endcase
        end
    end

    assign cop_hold = hold_for(st, run);
endmodule

// File: rtl/cop_word_sender.sv
module cop_word_sender
    import cws_pkg::*;
#(
    parameter int WORD_W         = WORD_W_DEF,
    parameter int RESET_CYCLES   = 8,
    parameter int STARTUP_PULSES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    input  logic              cop_rdy,
    input  logic              cop_err,
    output logic [WORD_W-1:0] cop_word,
    output logic              cop_hold,
    output logic              cop_reset,
    output logic              err_out
);
    logic [1:0] raw_in;
    logic [1:0] synced;
    rdy_ev_t    ev;
    logic       run;

    assign raw_in = {cop_err, cop_rdy};

    cws_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(synced)
    );

    assign err_out = synced[1];

    cws_edge u_edge (
        .clk(clk), .rst(rst), .lvl(synced[0]), .ev(ev)
    );

    cws_startup #(
        .RESET_CYCLES(RESET_CYCLES), .STARTUP_PULSES(STARTUP_PULSES)
    ) u_start (
        .clk(clk), .rst(rst), .ev(ev), .cop_reset(cop_reset), .run(run)
    );

    cws_link #(.WORD_W(WORD_W)) u_link (
        .clk(clk), .rst(rst), .run(run), .ev(ev),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .cop_word(cop_word), .cop_hold(cop_hold)
    );
endmodule

// File: rtl/cop_word_sender_chk.sv
module cop_word_sender_chk #(
    parameter int WORD_W       = 6,
    parameter int RESET_CYCLES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              cop_err,
    input logic [WORD_W-1:0] cop_word,
    input logic              cop_hold,
    input logic              cop_reset,
    input logic              err_out
);
    int unsigned rcnt;
    int unsigned since;

    always_ff @(posedge clk) begin
        if (rst) begin
            rcnt  <= 0;
            since <= 0;
        end else begin
            if (cop_reset) rcnt <= rcnt + 1;
            if (since < 4) since <= since + 1;
        end
    end

    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (cop_reset && !cop_hold && !in_ready && cop_word == '0));

    p_reset_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cop_reset) |-> (rcnt == RESET_CYCLES));

    p_reset_not_long_r2: assert property (@(posedge clk) disable iff (rst)
        cop_reset |-> (rcnt < RESET_CYCLES));

    p_startup_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        cop_reset |-> (!cop_hold && !in_ready));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> cop_hold);

    p_offer_low_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !cop_hold);

    p_word_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(cop_word));

    p_one_per_slot_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    p_err_delay_r9: assert property (@(posedge clk) disable iff (rst)
        (since >= 2) |-> (err_out == $past(cop_err, 2)));
endmodule

bind cop_word_sender cop_word_sender_chk #(
    .WORD_W(WORD_W), .RESET_CYCLES(RESET_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .cop_err(cop_err), .cop_word(cop_word), .cop_hold(cop_hold),
    .cop_reset(cop_reset), .err_out(err_out)
);

// File: tb/tb_cop_word_sender.sv
module tb_cop_word_sender;
    localparam int W  = 6;
    localparam int RC = 8;
    localparam int NW = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_word = '0;
    logic         in_ready;
    logic         cop_rdy = 1'b0;
    logic         cop_err = 1'b0;
    logic [W-1:0] cop_word;
    logic         cop_hold;
    logic         cop_reset;
    logic         err_out;

    int nchk = 0;
    int nbad = 0;
    int raised = 0;
    bit over = 1'b0;

    always #5 clk = ~clk;

    cop_word_sender #(.WORD_W(W), .RESET_CYCLES(RC), .STARTUP_PULSES(2)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .cop_rdy(cop_rdy), .cop_err(cop_err),
        .cop_word(cop_word), .cop_hold(cop_hold), .cop_reset(cop_reset),
        .err_out(err_out)
    );

    function automatic logic [W-1:0] pat(input int n);
        return W'((n * 37) % 64);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    endtask

    task automatic upstream();
        for (int n = 0; n < NW; n++) begin
            if (n % 8 == 0 && n > 0) begin
                while (!in_ready) @(negedge clk);
                repeat (40) @(negedge clk);
            end
            in_valid = 1'b1;
            in_word  = pat(n);
            while (!in_ready) @(negedge clk);
            // R8: word n>=1 only after the ready line rose again for it
            check(raised >= ((n == 0) ? 0 : n + 1), "R8 accept after consume",
                  raised, (n == 0) ? 0 : n + 1);
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic coproc();
        for (int n = 0; n < NW; n++) begin
            int w;
            repeat (2 + n % 3) @(negedge clk);
            cop_rdy = 1'b1;
            raised++;
            w = 0;
            @(negedge clk);
            while (cop_hold) begin
                w++;
                @(negedge clk);
            end
            if (n % 8 == 0 && n > 0)
                check(w >= 40, "R4 hold high while idle", w, 40);
            check(cop_word == pat(n), "R6 word value/order", int'(cop_word), int'(pat(n)));
            cop_rdy = 1'b0;
            @(negedge clk);
            check(cop_hold == 1'b0, "R5 hold low until fall seen", int'(cop_hold), 0);
            for (int j = 0; j < 1 + n % 3; j++) begin
                repeat (3) @(negedge clk);
                check(cop_word == pat(n), "R7 word stable over samples",
                      int'(cop_word), int'(pat(n)));
            end
        end
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R1 reset values
        check(cop_reset == 1'b1, "R1 cop_reset", int'(cop_reset), 1);
        check(cop_hold == 1'b0, "R1 cop_hold", int'(cop_hold), 0);
        check(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
        check(cop_word == '0, "R1 cop_word", int'(cop_word), 0);
        check(err_out == 1'b0, "R1 err_out", int'(err_out), 0);
        rst = 1'b0;
        cnt = 0;
        while (cop_reset) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == RC, "R2 reset length", cnt, RC);
        repeat (3) @(negedge clk);
        // R3: two start-up pulses, hold and in_ready stay low
        for (int p = 0; p < 2; p++) begin
            cop_rdy = 1'b1;
            repeat (5) begin
                @(negedge clk);
                check(!cop_hold && !in_ready, "R3 quiet in pulse",
                      int'({cop_hold, in_ready}), 0);
            end
            cop_rdy = 1'b0;
            if (p == 0) begin
                repeat (5) begin
                    @(negedge clk);
                    check(!cop_hold && !in_ready, "R3 quiet between pulses",
                          int'({cop_hold, in_ready}), 0);
                end
            end
        end
        @(negedge clk);
        @(negedge clk);
        check(in_ready == 1'b0, "R3 in_ready still low", int'(in_ready), 0);
        @(negedge clk);
        check(in_ready == 1'b1, "R3 in_ready up on third edge", int'(in_ready), 1);
        check(cop_hold == 1'b1, "R4 hold high when empty", int'(cop_hold), 1);
        fork
            upstream();
            coproc();
        join
        // R9 error pass-through latency
        repeat (4) @(negedge clk);
        cop_err = 1'b1;
        @(negedge clk);
        check(err_out == 1'b0, "R9 err one edge", int'(err_out), 0);
        @(negedge clk);
        check(err_out == 1'b1, "R9 err two edges", int'(err_out), 1);
        cop_err = 1'b0;
        @(negedge clk);
        check(err_out == 1'b1, "R9 err clear one edge", int'(err_out), 1);
        @(negedge clk);
        check(err_out == 1'b0, "R9 err clear two edges", int'(err_out), 0);
        over = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!over) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule